// File: doc/BRIEF.md
# SDRAM Command Controller with Periodic Refresh

This block sits between a simple request port and one synchronous DRAM device with a 16-bit data bus and four banks. It issues single-beat reads and writes. Each access opens a row with ACTIVE. After the row-to-column delay it issues a column command that carries the auto-precharge flag, so the bank closes by itself. The controller then waits out the read latency or write recovery plus the precharge time before it takes new work. Commands are encoded on chip select, row strobe, column strobe and write enable. Bank, row, column and mode word go out on the bank and address pins.

After reset the controller waits a settling period. It then precharges all banks, issues two auto-refreshes and loads the mode register with burst length one, sequential order and the configured CAS latency. Only after that does it accept requests. A free-running timer raises a refresh demand once per refresh slot. The slot is the refresh period in milliseconds times the clock rate in kHz, divided by the refresh count. The demand is served at the next idle point, ahead of any waiting request. Read data is captured from the device data pins after the CAS latency and presented with a one-cycle valid strobe.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the command pins show NOP (cs,ras,cas,we = 0111). During reset, init_done, req_ready and rd_valid are 0.
- R2: After reset is released, the command pins show a fixed start-up sequence at exact cycle numbers. PRECHARGE with address bit 10 high appears T_INIT cycles after release. AUTO REFRESH follows T_RP cycles later, a second AUTO REFRESH T_RFC cycles after that, and LOAD MODE T_RFC cycles after the second refresh. init_done rises together with LOAD MODE, and req_ready is never high before init_done.
- R3: The LOAD MODE address word equals CAS_LAT placed in bits 6:4, with every other bit zero (burst length one, sequential order, burst writes).
- R4: Every command uses one of these cs,ras,cas,we codes: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R5: An accepted request produces ACTIVE on the next cycle, with the request bank on the bank pins and the row on the address pins. READ or WRITE follows exactly T_RCD cycles later on the same bank. Its address carries the column in bits 8:0 and bit 10 high (auto-precharge).
- R6: On the WRITE cycle the data output enable is high and the request data is driven. The byte masks equal the request mask, where mask bit 0 covers bits 7:0 and bit 1 covers bits 15:8; a 1 disables that lane, so the device leaves those bits unchanged. Masks are low on every other cycle, and the output enable is low except on WRITE.
- R7: rd_valid pulses for one cycle exactly CAS_LAT+1 cycles after a READ appears on the pins. rd_data holds the word the device drove, and every read returns the value written last to that location, after masking.
- R8: After READ the next command comes no sooner than CAS_LAT+T_RP cycles, and after WRITE no sooner than T_WR+T_RP cycles.
- R9: A refresh demand is raised once every refresh slot. It is served ahead of a request offered in the same cycle, so req_ready is low in the cycle before every AUTO REFRESH. Successive refreshes are never further apart than one slot plus the longest access.
- R10: After AUTO REFRESH the next command comes no sooner than T_RFC cycles. After LOAD MODE it comes no sooner than T_MRD cycles.
- R11: A request is taken only in a cycle where req_valid and req_ready are both high. A request held while req_ready is low produces no ACTIVE, so the number of ACTIVE commands equals the number of accepted requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DATA_W | Write data |
| req_wmask | input | DATA_W/8 | Per-byte write disable, 1 = lane untouched |
| req_ready | output | 1 | Request is taken at this edge if valid |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Read data |
| init_done | output | 1 | Start-up sequence finished |
| sd_cs_n | output | 1 | Device chip select |
| sd_ras_n | output | 1 | Device row strobe |
| sd_cas_n | output | 1 | Device column strobe |
| sd_we_n | output | 1 | Device write enable |
| sd_ba | output | BANK_W | Device bank address |
| sd_addr | output | ROW_W | Device address bus |
| sd_dqm | output | DATA_W/8 | Device byte masks |
| sd_dq_out | output | DATA_W | Data driven toward the device |
| sd_dq_oe | output | 1 | Enable for sd_dq_out |
| sd_dq_in | input | DATA_W | Data returned by the device |

## Verification
The refresh timer can raise its demand in the same cycle that a user request is waiting in idle, and the controller must choose the refresh. The bench provokes this by streaming back-to-back requests with req_valid never dropped, for several refresh slots shortened through the parameters. At every AUTO REFRESH it checks three things: req_ready was low in the prior cycle, the bench had a request waiting in at least one such case, and the gap from the previous refresh stays within one slot plus one access. A behavioural device model with its own memory then confirms that no write or read was lost around those refreshes.

// File: rtl/sdram_ctrl_pkg.sv
// Shared command encoding for the SDRAM controller.
// Bit order of the code is {cs_n, ras_n, cas_n, we_n}.
package sdram_ctrl_pkg;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

endpackage

// File: rtl/sdram_ref_timer.sv
// Refresh slot timer.
// Raises a sticky demand once every INTERVAL cycles and holds it until the
// sequencer acknowledges. Assumes INTERVAL >= 2 and that a slot is far
// longer than the time the demand waits for service.
module sdram_ref_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic pend_o
);
    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] slot_cnt;
    logic          slot_end;

    assign slot_end = (slot_cnt == CW'(INTERVAL - 1));

    // Count cycles within the current refresh slot.
    always_ff @(posedge clk) begin
        if (!rst_n)        slot_cnt <= '0;
        else if (slot_end) slot_cnt <= '0;
        else               slot_cnt <= slot_cnt + 1'b1;
    end

    // Set the demand at slot end, clear it on acknowledge (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_o <= 1'b0;
        else if (slot_end) pend_o <= 1'b1;
        else if (ack_i)    pend_o <= 1'b0;
    end

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !ack_i) |=> pend_o);

endmodule

// File: rtl/sdram_rd_capture.sv
// Read data return path.
// Delays a read-issued flag by the CAS latency and samples the device data
// at the edge where the word is valid. Assumes single-beat bursts and that
// the read flag is the registered command already on the pins.
module sdram_rd_capture #(
    parameter int CAS_LAT = 2,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [CAS_LAT-1:0] lat_sh;

    generate
        if (CAS_LAT == 1) begin : g_sh1
            // Single-stage latency tracker.
            always_ff @(posedge clk) begin
                if (!rst_n) lat_sh <= '0;
                else        lat_sh <= rd_issue_i;
            end
        end else begin : g_shn
            // Multi-stage latency tracker.
            always_ff @(posedge clk) begin
                if (!rst_n) lat_sh <= '0;
                else        lat_sh <= {lat_sh[CAS_LAT-2:0], rd_issue_i};
            end
        end
    endgenerate

    // Strobe and capture the returned word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= lat_sh[CAS_LAT-1];
            if (lat_sh[CAS_LAT-1]) rd_data_o <= dq_i;
        end
    end

    // R7
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_issue_i, CAS_LAT + 1));

endmodule

// File: rtl/sdram_cmd_seq.sv
// Command sequencer.
// Runs the start-up sequence, then serves refresh demands and single-beat
// accesses with auto-precharge. All device outputs are registered. Every
// wait in the state machine is one shared down-counter loaded with
// (gap - 2), so the next command lands exactly `gap` cycles later.
// Assumes every timing parameter is >= 2 and COL_W <= 10.
module sdram_cmd_seq
    import sdram_ctrl_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 9,
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 2,
    parameter int T_INIT  = 20,
    parameter int T_RCD   = 2,
    parameter int T_RP    = 2,
    parameter int T_RFC   = 6,
    parameter int T_WR    = 2,
    parameter int T_MRD   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic [BANK_W-1:0]   req_bank_i,
    input  logic [ROW_W-1:0]    req_row_i,
    input  logic [COL_W-1:0]    req_col_i,
    input  logic [DATA_W-1:0]   req_wdata_i,
    input  logic [DATA_W/8-1:0] req_wmask_i,
    input  logic                ref_pend_i,
    output logic                req_ready_o,
    output logic                ref_ack_o,
    output logic                init_done_o,
    output sd_cmd_e             cmd_o,
    output logic [BANK_W-1:0]   ba_o,
    output logic [ROW_W-1:0]    addr_o,
    output logic [DATA_W/8-1:0] dqm_o,
    output logic [DATA_W-1:0]   dq_o,
    output logic                oe_o
);
    localparam int MASK_W   = DATA_W / 8;
    localparam int AP_BIT   = 10;
    localparam int WAIT_MAX = T_INIT + T_RCD + T_RP + T_RFC + T_WR + T_MRD + CAS_LAT;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);
    localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1 << AP_BIT);

    typedef enum logic [2:0] {
        ST_PWR, ST_IREF1, ST_IREF2, ST_IMRS, ST_IDLE, ST_RW, ST_WAIT
    } seq_st_e;

    seq_st_e             st, ret_st;
    logic [CNT_W-1:0]    cnt;
    logic                lat_write;
    logic [BANK_W-1:0]   lat_bank;
    logic [COL_W-1:0]    lat_col;
    logic [DATA_W-1:0]   lat_wdata;
    logic [MASK_W-1:0]   lat_mask;
    logic [ROW_W-1:0]    col_word;

    assign req_ready_o = (st == ST_IDLE) && !ref_pend_i;
    assign ref_ack_o   = (st == ST_IDLE) &&  ref_pend_i;

    // Column word: column in the low bits, auto-precharge flag on bit 10.
    always_comb begin
        col_word                = '0;
        col_word[COL_W-1:0]     = lat_col;
        col_word[AP_BIT]        = 1'b1;
    end

    // Main sequencer: state, wait counter, latched request and pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_PWR;
            ret_st      <= ST_IDLE;
            cnt         <= CNT_W'(T_INIT - 1);
            cmd_o       <= CMD_NOP;
            ba_o        <= '0;
            addr_o      <= '0;
            dqm_o       <= '0;
            dq_o        <= '0;
            oe_o        <= 1'b0;
            init_done_o <= 1'b0;
            lat_write   <= 1'b0;
            lat_bank    <= '0;
            lat_col     <= '0;
            lat_wdata   <= '0;
            lat_mask    <= '0;
        end else begin
            cmd_o <= CMD_NOP;
            oe_o  <= 1'b0;
            dqm_o <= '0;
            case (st)
                ST_PWR: begin
                    if (cnt == '0) begin
                        cmd_o  <= CMD_PRE;
                        addr_o <= ALL_BANKS;
                        ba_o   <= '0;
                        cnt    <= CNT_W'(T_RP - 2);
                        ret_st <= ST_IREF1;
                        st     <= ST_WAIT;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_IREF1, ST_IREF2: begin
                    cmd_o  <= CMD_REF;
                    cnt    <= CNT_W'(T_RFC - 2);
                    ret_st <= (st == ST_IREF1) ? ST_IREF2 : ST_IMRS;
                    st     <= ST_WAIT;
                end
                ST_IMRS: begin
                    cmd_o       <= CMD_LMR;
                    addr_o      <= MODE_WORD;
                    ba_o        <= '0;
                    init_done_o <= 1'b1;
                    cnt         <= CNT_W'(T_MRD - 2);
                    ret_st      <= ST_IDLE;
                    st          <= ST_WAIT;
                end
                ST_IDLE: begin
                    if (ref_pend_i) begin
                        cmd_o  <= CMD_REF;
                        cnt    <= CNT_W'(T_RFC - 2);
                        ret_st <= ST_IDLE;
                        st     <= ST_WAIT;
                    end else if (req_valid_i) begin
                        cmd_o     <= CMD_ACT;
                        ba_o      <= req_bank_i;
                        addr_o    <= req_row_i;
                        lat_write <= req_write_i;
                        lat_bank  <= req_bank_i;
                        lat_col   <= req_col_i;
                        lat_wdata <= req_wdata_i;
                        lat_mask  <= req_wmask_i;
                        cnt       <= CNT_W'(T_RCD - 2);
                        ret_st    <= ST_RW;
                        st        <= ST_WAIT;
                    end
                end
                ST_RW: begin
                    ba_o   <= lat_bank;
                    addr_o <= col_word;
                    ret_st <= ST_IDLE;
                    st     <= ST_WAIT;
                    if (lat_write) begin
                        cmd_o <= CMD_WR;
                        dq_o  <= lat_wdata;
                        oe_o  <= 1'b1;
                        dqm_o <= lat_mask;
                        cnt   <= CNT_W'(T_WR + T_RP - 2);
                    end else begin
                        cmd_o <= CMD_RD;
                        cnt   <= CNT_W'(CAS_LAT + T_RP - 2);
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) st  <= ret_st;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9
    ref_ack_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack_o |=> (cmd_o == CMD_REF));

    // R9
    ref_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend_i |-> !req_ready_o);

endmodule

// File: rtl/sdram_ctrl.sv
// SDRAM controller top.
// Ties the refresh slot timer, the command sequencer and the read capture
// path together and splits the registered command onto the four strobes.
// Assumes one device, single-beat accesses and a clock rate given in kHz.
module sdram_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int BANK_W        = 2,
    parameter int ROW_W         = 12,
    parameter int COL_W         = 9,
    parameter int DATA_W        = 16,
    parameter int CAS_LAT       = 2,
    parameter int T_INIT        = 20,
    parameter int T_RCD         = 2,
    parameter int T_RP          = 2,
    parameter int T_RFC         = 6,
    parameter int T_WR          = 2,
    parameter int T_MRD         = 2,
    parameter int CLK_KHZ       = 50000,
    parameter int REF_PERIOD_MS = 64,
    parameter int REF_COUNT     = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]    req_row,
    input  logic [COL_W-1:0]    req_col,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_wmask,
    output logic                req_ready,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                init_done,
    output logic                sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [BANK_W-1:0]   sd_ba,
    output logic [ROW_W-1:0]    sd_addr,
    output logic [DATA_W/8-1:0] sd_dqm,
    output logic [DATA_W-1:0]   sd_dq_out,
    output logic                sd_dq_oe,
    input  logic [DATA_W-1:0]   sd_dq_in
);
    localparam int REF_INTERVAL = CLK_KHZ * REF_PERIOD_MS / REF_COUNT;

    sd_cmd_e cmd;
    logic    ref_pend;
    logic    ref_ack;

    sdram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (ref_ack),
        .pend_o (ref_pend)
    );

    sdram_cmd_seq #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .CAS_LAT(CAS_LAT), .T_INIT(T_INIT), .T_RCD(T_RCD), .T_RP(T_RP),
        .T_RFC(T_RFC), .T_WR(T_WR), .T_MRD(T_MRD)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_bank_i  (req_bank),
        .req_row_i   (req_row),
        .req_col_i   (req_col),
        .req_wdata_i (req_wdata),
        .req_wmask_i (req_wmask),
        .ref_pend_i  (ref_pend),
        .req_ready_o (req_ready),
        .ref_ack_o   (ref_ack),
        .init_done_o (init_done),
        .cmd_o       (cmd),
        .ba_o        (sd_ba),
        .addr_o      (sd_addr),
        .dqm_o       (sd_dqm),
        .dq_o        (sd_dq_out),
        .oe_o        (sd_dq_oe)
    );

    sdram_rd_capture #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_rd_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_issue_i (cmd == CMD_RD),
        .dq_i       (sd_dq_in),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    // R11
    accept_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd == CMD_ACT));

    // R2
    ready_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> init_done);

    // R6
    oe_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cmd == CMD_WR && sd_addr[10]));

endmodule

// File: tb/sdram_ctrl_tb.sv
// Bench: behavioural device model plus request-level mirror, checked each cycle.
module sdram_ctrl_tb;
    localparam int CL = 3, TI = 20, TRCD = 3, TRP = 3, TRFC = 7, TWR = 2, TMRD = 2;
    localparam int KHZ = 6400, PMS = 1, RCNT = 64;
    localparam int RI = KHZ * PMS / RCNT;
    localparam int SLACK = TRCD + CL + TWR + TRP + 4;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
        C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

    typedef struct {
        logic w; logic [1:0] b; logic [11:0] r; logic [8:0] c;
        logic [15:0] d; logic [1:0] m;
    } req_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_bank = '0, req_wmask = '0;
    logic [11:0] req_row = '0;
    logic [8:0] req_col = '0;
    logic [15:0] req_wdata = '0;
    logic req_ready, rd_valid, init_done;
    logic [15:0] rd_data, sd_dq_out, sd_dq_in;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0] sd_ba, sd_dqm;
    logic [11:0] sd_addr;

    always #10 clk = ~clk;

    sdram_ctrl #(.CAS_LAT(CL), .T_INIT(TI), .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC),
        .T_WR(TWR), .T_MRD(TMRD), .CLK_KHZ(KHZ), .REF_PERIOD_MS(PMS), .REF_COUNT(RCNT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .req_wmask(req_wmask), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .init_done(init_done),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    bit fin = 1'b0;

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int key(logic [1:0] b, logic [11:0] r, logic [8:0] c);
        return (int'(b) << 21) | (int'(r) << 9) | int'(c);
    endfunction

    function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] nw, logic [1:0] m);
        logic [15:0] v = old;
        if (!m[0]) v[7:0]  = nw[7:0];
        if (!m[1]) v[15:8] = nw[15:8];
        return v;
    endfunction

    // request-side mirror and queues
    logic [15:0] mirror [int];
    logic [15:0] dmem [int];
    req_t acc_q [$];
    logic [15:0] exp_q [$];
    int rdcyc_q [$];
    int drv_cyc_q [$];
    logic [15:0] drv_dat_q [$];
    int n_acc = 0;

    task automatic do_req(bit w, logic [1:0] b, logic [11:0] r, logic [8:0] c,
                          logic [15:0] d, logic [1:0] m);
        req_t t;
        int k;
        t.w = w; t.b = b; t.r = r; t.c = c; t.d = d; t.m = m;
        req_valid = 1'b1; req_write = w; req_bank = b; req_row = r;
        req_col = c; req_wdata = d; req_wmask = m;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        acc_q.push_back(t);
        n_acc++;
        k = key(b, r, c);
        if (w) mirror[k] = merge(mirror.exists(k) ? mirror[k] : 16'hDEAD, d, m);
        else   exp_q.push_back(mirror.exists(k) ? mirror[k] : 16'hDEAD);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor and device model
    int cyc = 0, last_cyc = 0, last_ref = 0, init_idx = 0, n_act = 0, n_ref = 0, n_coll = 0;
    logic [3:0] last_cmd = 4'b0111;
    logic prev_ready = 1'b0, prev_valid = 1'b0;
    logic [11:0] open_row [4];
    req_t cur;

    function automatic int gap_need(logic [3:0] c);
        case (c)
            C_PRE: return TRP;
            C_REF: return TRFC;
            C_LMR: return TMRD;
            C_ACT: return TRCD;
            C_RD:  return CL + TRP;
            C_WR:  return TWR + TRP;
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        logic [3:0] cm;
        if (rst_n) begin
            cyc++;
            cm = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (cyc == 1) chk(cm == C_NOP, "R1", "first cycle after reset", cm, C_NOP);
            if (cm != C_WR) begin
                chk(sd_dqm == 2'b00 && !sd_dq_oe, "R6", "masks/oe idle outside write",
                    {sd_dq_oe, sd_dqm}, 0);
            end
            if (cm != C_NOP) begin
                chk(cm inside {C_ACT, C_RD, C_WR, C_PRE, C_REF, C_LMR}, "R4", "legal code", cm, C_NOP);
                if (init_idx < 4) begin
                    int ec;
                    logic [3:0] ek;
                    ec = (init_idx == 0) ? TI : (init_idx == 1) ? TI + TRP :
                         (init_idx == 2) ? TI + TRP + TRFC : TI + TRP + 2 * TRFC;
                    ek = (init_idx == 0) ? C_PRE : (init_idx == 3) ? C_LMR : C_REF;
                    chk(cm == ek, "R2", "start-up command", cm, ek);
                    chk(cyc == ec, "R2", "start-up cycle", cyc, ec);
                    if (init_idx == 0) chk(sd_addr[10] == 1'b1, "R2", "precharge-all flag", sd_addr[10], 1);
                    if (init_idx == 3) begin
                        chk(sd_addr == 12'(CL << 4), "R3", "mode word", sd_addr, CL << 4);
                        chk(init_done == 1'b1, "R2", "init_done with mode load", init_done, 1);
                    end
                    if (init_idx == 3) last_ref = cyc;
                    init_idx++;
                end else if (last_cmd == C_ACT) begin
                    chk(cm == (cur.w ? C_WR : C_RD), "R5", "column command kind", cm, cur.w ? C_WR : C_RD);
                    chk(cyc - last_cyc == TRCD, "R5", "row-to-column gap", cyc - last_cyc, TRCD);
                    chk(sd_ba == cur.b, "R5", "column bank", sd_ba, cur.b);
                    chk(sd_addr[8:0] == cur.c && sd_addr[10], "R5", "column + auto-precharge",
                        sd_addr, {3'b010, cur.c});
                end else begin
                    chk(cm == C_ACT || cm == C_REF, "R11", "command from idle", cm, C_ACT);
                    chk(cyc - last_cyc >= gap_need(last_cmd),
                        (last_cmd == C_RD || last_cmd == C_WR) ? "R8" : "R10",
                        "command spacing", cyc - last_cyc, gap_need(last_cmd));
                end
                if (cm == C_ACT) begin
                    n_act++;
                    if (acc_q.size() == 0) chk(1'b0, "R11", "ACTIVE without accepted request", 1, 0);
                    else begin
                        cur = acc_q.pop_front();
                        chk(sd_ba == cur.b && sd_addr == cur.r, "R5", "bank/row on ACTIVE",
                            {sd_ba, sd_addr}, {cur.b, cur.r});
                    end
                    open_row[sd_ba] = sd_addr;
                end
                if (cm == C_REF && init_idx >= 4 && last_cmd != C_REF || (cm == C_REF && cyc > TI + TRP + 2 * TRFC)) begin
                    n_ref++;
                    chk(prev_ready == 1'b0, "R9", "ready low before refresh", prev_ready, 0);
                    chk(cyc - last_ref <= RI + SLACK, "R9", "refresh interval", cyc - last_ref, RI + SLACK);
                    if (prev_valid) n_coll++;
                    last_ref = cyc;
                end
                if (cm == C_WR) begin
                    int k;
                    chk(sd_dq_oe && sd_dqm == cur.m && sd_dq_out == cur.d, "R6", "write pins",
                        {sd_dq_oe, sd_dqm, sd_dq_out}, {1'b1, cur.m, cur.d});
                    k = key(sd_ba, open_row[sd_ba], sd_addr[8:0]);
                    dmem[k] = merge(dmem.exists(k) ? dmem[k] : 16'hDEAD, sd_dq_out, sd_dqm);
                end
                if (cm == C_RD) begin
                    int k;
                    k = key(sd_ba, open_row[sd_ba], sd_addr[8:0]);
                    drv_cyc_q.push_back(cyc + CL);
                    drv_dat_q.push_back(dmem.exists(k) ? dmem[k] : 16'hDEAD);
                    rdcyc_q.push_back(cyc);
                end
                last_cmd = cm;
                last_cyc = cyc;
            end
            if (rd_valid) begin
                if (rdcyc_q.size() == 0 || exp_q.size() == 0) chk(1'b0, "R7", "unexpected rd_valid", 1, 0);
                else begin
                    int rc;
                    logic [15:0] ev;
                    rc = rdcyc_q.pop_front();
                    ev = exp_q.pop_front();
                    chk(cyc - rc == CL + 1, "R7", "read latency", cyc - rc, CL + 1);
                    chk(rd_data == ev, "R7", "read data", rd_data, ev);
                end
            end
            if (drv_cyc_q.size() != 0 && drv_cyc_q[0] == cyc) begin
                void'(drv_cyc_q.pop_front());
                sd_dq_in = drv_dat_q.pop_front();
            end
            prev_ready = req_ready;
            prev_valid = req_valid;
        end
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "NOP in reset",
                {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
            chk(!init_done && !req_ready && !rd_valid, "R1", "flags in reset",
                {init_done, req_ready, rd_valid}, 0);
        end
        #5 rst_n = 1'b1;
        while (!init_done) @(negedge clk);
        @(negedge clk);
        // directed accesses
        do_req(1'b1, 2'd0, 12'd5, 9'd3, 16'h1234, 2'b00);
        do_req(1'b0, 2'd0, 12'd5, 9'd3, 16'h0, 2'b00);
        do_req(1'b1, 2'd3, 12'hFFF, 9'h1FF, 16'hABCD, 2'b00);
        do_req(1'b1, 2'd3, 12'hFFF, 9'h1FF, 16'h5678, 2'b10);   // R6 upper lane disabled
        do_req(1'b0, 2'd3, 12'hFFF, 9'h1FF, 16'h0, 2'b00);
        do_req(1'b1, 2'd3, 12'hFFF, 9'h1FF, 16'h9999, 2'b11);   // R6 both lanes disabled
        do_req(1'b0, 2'd3, 12'hFFF, 9'h1FF, 16'h0, 2'b00);
        do_req(1'b1, 2'd2, 12'h400, 9'd0, 16'hC3C3, 2'b01);
        do_req(1'b0, 2'd2, 12'h400, 9'd0, 16'h0, 2'b00);
        // streaming requests spanning several refresh slots (R9 collisions)
        for (int i = 0; i < 60; i++) begin
            logic [1:0] b;
            logic [11:0] r;
            logic [8:0] c;
            int j;
            j = (i % 2 == 0) ? i : i - 1;
            b = 2'(j % 4); r = 12'((j * 37) % 4096); c = 9'((j * 5) % 512);
            if (i % 2 == 0) do_req(1'b1, b, r, c, 16'((i * 16'h1111) ^ 16'h0F0F), (i % 6 == 0) ? 2'b01 : 2'b00);
            else            do_req(1'b0, b, r, c, 16'h0, 2'b00);
        end
        repeat (3 * RI) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "all reads returned", exp_q.size(), 0);
        chk(n_act == n_acc, "R11", "ACTIVE count vs accepted", n_act, n_acc);
        chk(n_coll >= 1, "R9", "refresh beat waiting request", n_coll, 1);
        chk(n_ref >= cyc / (RI + SLACK) - 1, "R9", "refresh count", n_ref, cyc / (RI + SLACK) - 1);
        fin = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule